// File: doc/BRIEF.md
# Microcode ALU with Q Register

This block is the arithmetic and logic stage of a horizontally microcoded datapath. Each cycle it combines an A operand and an M operand under a 5-bit function code. It picks a carry-in from one of four sources and drives an output-bus word that may be the raw result, the result shifted one place either way, or an externally supplied masker word. It reports carry, zero and overflow for the current operation.

Two pieces of state live inside the block. The first is the carry-out saved from the previous operation, so that multi-word arithmetic can chain through it. The second is a Q register that can hold, shift left, shift right or load from the output bus on every clock. A conditional-operation flag reinterprets the function code so that Q's low bit decides between two arithmetic forms. This gives single-cycle multiply steps and divide steps; the microcode iterates them together with the Q shift controls.

Top module: `mcalu_top`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears Q to 0 and clears the saved carry to 0.
- R2: With op_cond=0, codes 0..15 compute, bit by bit with A and M: 0 ~A, 1 ~A&~M, 2 ~A&M, 3 zero, 4 ~(A&M), 5 ~M, 6 A^M, 7 A&~M, 8 ~A|M, 9 ~(A^M), 10 M, 11 A&M, 12 all ones, 13 A|~M, 14 A|M, 15 A. Carry and overflow are 0 for these codes.
- R3: With op_cond=0, codes 16..20 compute X+Y+cin as 33 bits, where carry is bit 32. The (X,Y) pairs are: 16 (A,1), 17 (A,~M), 18 (A,M), 19 (A,A), 20 (A,all ones).
- R4: Unassigned codes (21..31 with op_cond=0; 2..31 with op_cond=1) give a result of 0 with carry 0 and overflow 0.
- R5: cin_sel selects the carry-in: 0 gives 0, 1 gives 1, 2 gives the saved carry, and 3 gives Q bit 0.
- R6: At every rising edge out of reset, the saved carry captures the current carry output.
- R7: Overflow is set when X and Y have the same sign and the result sign differs from it. zero_out is set when all 32 bits of bus_out are 0.
- R8: out_sel selects bus_out: 0 gives the result; 1 gives the result shifted right one place with the carry output entering bit 31; 2 gives the result shifted left one place with 0 entering bit 0; 3 gives mask_in.
- R9: q_ctl acts at the rising edge: 0 holds Q. 1 shifts Q left with the inverse of result bit 31 entering bit 0. 2 shifts Q right with result bit 0 entering bit 31. 3 loads bus_out.
- R10: Multiply step (op_cond=1, code 0) computes A+M+cin when Q[0]=1 and A+cin when Q[0]=0. Iterated with out_sel=1 and q_ctl=2, it forms the product with the high part on the bus and the low part in Q's top bits.
- R11: Divide step (op_cond=1, code 1) computes A+~M+cin when Q[0]=1 and A+M+cin when Q[0]=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 32 | A operand |
| m_in | input | 32 | M operand |
| op_code | input | 5 | Function code |
| op_cond | input | 1 | Conditional (Q-dependent) operation select |
| cin_sel | input | 2 | Carry-in source select |
| q_ctl | input | 2 | Q register control |
| out_sel | input | 2 | Output bus source select |
| mask_in | input | 32 | Masker word from the byte unit |
| bus_out | output | 32 | Output bus word |
| carry_out | output | 1 | Carry of the current operation |
| zero_out | output | 1 | Output bus is all zero |
| ovf_out | output | 1 | Signed overflow of the current operation |
| q_out | output | 32 | Q register contents |

## Verification
The block holds only two state elements, and a wrong value in either shows at the ports in the very next operation that reads it. A corrupted saved carry appears in bus_out and carry_out as soon as an add selects cin_sel=2. A bad Q shows directly on q_out one edge after the faulty update. It also shows through cin_sel=3 or the multiply and divide steps, where a wrong Q[0] changes the sum in the same cycle. The iterated multiply compares a complete product, so an error in fill direction or operand choice that slips past a single step surfaces after at most four steps.

// File: rtl/mcalu_pkg.sv
package mcalu_pkg;

   typedef enum logic [1:0] {
      CIN_ZERO  = 2'd0,
      CIN_ONE   = 2'd1,
      CIN_SAVED = 2'd2,
      CIN_QLSB  = 2'd3
   } cin_sel_e;

   typedef enum logic [1:0] {
      QC_HOLD = 2'd0,
      QC_SHL  = 2'd1,
      QC_SHR  = 2'd2,
      QC_LOAD = 2'd3
   } qctl_e;

   typedef enum logic [1:0] {
      OB_RES   = 2'd0,
      OB_SHR   = 2'd1,
      OB_SHL   = 2'd2,
      OB_MASK  = 2'd3
   } obus_e;

   localparam logic [4:0] OP_SETZ = 5'd3;
   localparam logic [4:0] OP_INCA = 5'd16;
   localparam logic [4:0] OP_SUB  = 5'd17;
   localparam logic [4:0] OP_ADD  = 5'd18;
   localparam logic [4:0] OP_LSHA = 5'd19;
   localparam logic [4:0] OP_DECA = 5'd20;

   localparam logic [4:0] CND_MUL = 5'd0;
   localparam logic [4:0] CND_DIV = 5'd1;

   // Truth table of a boolean code, indexed by {a_bit, m_bit}
   function automatic logic [3:0] bool_table(input logic [3:0] code);
      logic [3:0] t;
      case (code)
         4'd0:  t = 4'b0011;
         4'd1:  t = 4'b0001;
         4'd2:  t = 4'b0010;
         4'd3:  t = 4'b0000;
         4'd4:  t = 4'b0111;
         4'd5:  t = 4'b0101;
         4'd6:  t = 4'b0110;
         4'd7:  t = 4'b0100;
         4'd8:  t = 4'b1011;
         4'd9:  t = 4'b1001;
         4'd10: t = 4'b1010;
         4'd11: t = 4'b1000;
         4'd12: t = 4'b1111;
         4'd13: t = 4'b1101;
         4'd14: t = 4'b1110;
         default: t = 4'b1100;
      endcase
      return t;
   endfunction

endpackage

// File: rtl/mcalu_cin_mux.sv
module mcalu_cin_mux
   import mcalu_pkg::*;
(
   input  logic [1:0] sel,
   input  logic       saved_c,
   input  logic       q_lsb,
   output logic       cin
);
   always_comb begin
      case (cin_sel_e'(sel))
         CIN_ZERO:  cin = 1'b0;
         CIN_ONE:   cin = 1'b1;
         CIN_SAVED: cin = saved_c;
         default:   cin = q_lsb;
      endcase
   end
endmodule

// File: rtl/mcalu_logic.sv
module mcalu_logic
   import mcalu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] m,
   input  logic [3:0]   code,
   output logic [W-1:0] res
);
   logic [3:0] tt;

   always_comb tt = bool_table(code);

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign res[i] = tt[{a[i], m[i]}];
   end
endmodule

// File: rtl/mcalu_adder.sv
module mcalu_adder #(
   parameter int W = 32
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);
   localparam int FW = W + 1;
   logic [FW-1:0] full;

   always_comb begin
      full = {1'b0, x} + {1'b0, y} + FW'(cin);
      sum  = full[W-1:0];
      cout = full[W];
      ovf  = (x[W-1] == y[W-1]) && (full[W-1] != x[W-1]);
   end
endmodule

// File: rtl/mcalu_core.sv
module mcalu_core
   import mcalu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] m,
   input  logic [4:0]   op,
   input  logic         cond,
   input  logic         q_lsb,
   input  logic         cin,
   output logic [W-1:0] res,
   output logic         cout,
   output logic         ovf
);
   localparam logic [W-1:0] ONE  = W'(1);
   localparam logic [W-1:0] ONES = '1;

   logic [W-1:0] x, y, lres, sum;
   logic         arith, boolean_op, add_c, add_v;

   always_comb begin
      x          = a;
      y          = '0;
      arith      = 1'b0;
      boolean_op = 1'b0;
      if (!cond) begin
         if (!op[4]) begin
            boolean_op = 1'b1;
         end else begin
            arith = 1'b1;
            case (op)
               OP_INCA: y = ONE;
               OP_SUB:  y = ~m;
               OP_ADD:  y = m;
               OP_LSHA: y = a;
               OP_DECA: y = ONES;
               default: arith = 1'b0;
            endcase
         end
      end else begin
         case (op)
            CND_MUL: begin
               arith = 1'b1;
               y     = q_lsb ? m : '0;
            end
            CND_DIV: begin
               arith = 1'b1;
               y     = q_lsb ? ~m : m;
            end
            default: arith = 1'b0;
         endcase
      end
   end

   mcalu_logic #(.W(W)) u_logic (
      .a    (a),
      .m    (m),
      .code (op[3:0]),
      .res  (lres)
   );

   mcalu_adder #(.W(W)) u_adder (
      .x    (x),
      .y    (y),
      .cin  (cin),
      .sum  (sum),
      .cout (add_c),
      .ovf  (add_v)
   );

   always_comb begin
      res  = arith ? sum : (boolean_op ? lres : '0);
      cout = arith & add_c;
      ovf  = arith & add_v;
   end
endmodule

// File: rtl/mcalu_qreg.sv
module mcalu_qreg
   import mcalu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [1:0]   ctl,
   input  logic [W-1:0] load_d,
   input  logic         shl_in,
   input  logic         shr_in,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else begin
         case (qctl_e'(ctl))
            QC_HOLD: q <= q;
            QC_SHL:  q <= {q[W-2:0], shl_in};
            QC_SHR:  q <= {shr_in, q[W-1:1]};
            default: q <= load_d;
         endcase
      end
   end

   a_r1_q_cleared: assert property (@(posedge clk) rst |=> (q == '0));
   a_r9_q_hold: assert property (@(posedge clk) disable iff (rst)
      (ctl == 2'd0) |=> (q == $past(q)));
   a_r9_q_load: assert property (@(posedge clk) disable iff (rst)
      (ctl == 2'd3) |=> (q == $past(load_d)));
   a_r9_q_shl: assert property (@(posedge clk) disable iff (rst)
      (ctl == 2'd1) |=> (q[W-1:1] == $past(q[W-2:0])));
   a_r9_q_shr: assert property (@(posedge clk) disable iff (rst)
      (ctl == 2'd2) |=> (q[W-2:0] == $past(q[W-1:1])));
endmodule

// File: rtl/mcalu_top.sv
module mcalu_top
   import mcalu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] m_in,
   input  logic [4:0]   op_code,
   input  logic         op_cond,
   input  logic [1:0]   cin_sel,
   input  logic [1:0]   q_ctl,
   input  logic [1:0]   out_sel,
   input  logic [W-1:0] mask_in,
   output logic [W-1:0] bus_out,
   output logic         carry_out,
   output logic         zero_out,
   output logic         ovf_out,
   output logic [W-1:0] q_out
);
   if (W < 4) begin : g_bad_width
      $error("mcalu_top: W must be at least 4");
   end

   logic         saved_c;
   logic         cin;
   logic [W-1:0] res;
   logic [W-1:0] q;

   mcalu_cin_mux u_cin (
      .sel     (cin_sel),
      .saved_c (saved_c),
      .q_lsb   (q[0]),
      .cin     (cin)
   );

   mcalu_core #(.W(W)) u_core (
      .a     (a_in),
      .m     (m_in),
      .op    (op_code),
      .cond  (op_cond),
      .q_lsb (q[0]),
      .cin   (cin),
      .res   (res),
      .cout  (carry_out),
      .ovf   (ovf_out)
   );

   always_comb begin
      case (obus_e'(out_sel))
         OB_RES:  bus_out = res;
         OB_SHR:  bus_out = {carry_out, res[W-1:1]};
         OB_SHL:  bus_out = {res[W-2:0], 1'b0};
         default: bus_out = mask_in;
      endcase
      zero_out = (bus_out == '0);
   end

   always_ff @(posedge clk) begin
      if (rst) saved_c <= 1'b0;
      else     saved_c <= carry_out;
   end

   mcalu_qreg #(.W(W)) u_q (
      .clk    (clk),
      .rst    (rst),
      .ctl    (q_ctl),
      .load_d (bus_out),
      .shl_in (~res[W-1]),
      .shr_in (res[0]),
      .q      (q)
   );

   assign q_out = q;

   a_r2_bool_no_flags: assert property (@(posedge clk) disable iff (rst)
      (!op_cond && !op_code[4]) |-> (!carry_out && !ovf_out));
   a_r4_unused_cond_zero: assert property (@(posedge clk) disable iff (rst)
      (op_cond && op_code > 5'd1 && out_sel == 2'd0) |-> (bus_out == '0 && !carry_out));
   a_r8_masker_pass: assert property (@(posedge clk) disable iff (rst)
      (out_sel == 2'd3) |-> (bus_out == mask_in));
   a_r7_add_ovf_signs: assert property (@(posedge clk) disable iff (rst)
      (!op_cond && op_code == OP_ADD && ovf_out) |-> (a_in[W-1] == m_in[W-1]));
   a_r2_setz_zero: assert property (@(posedge clk) disable iff (rst)
      (!op_cond && op_code == OP_SETZ && out_sel != 2'd3) |-> zero_out);
endmodule

// File: tb/mcalu_top_tb_top.sv
module mcalu_top_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] a_in = '0, m_in = '0, mask_in = '0;
   logic [4:0]  op_code = '0;
   logic        op_cond = 1'b0;
   logic [1:0]  cin_sel = '0, q_ctl = '0, out_sel = '0;
   logic [31:0] bus_out, q_out;
   logic        carry_out, zero_out, ovf_out;

   int errors = 0;
   int checks = 0;
   logic [31:0] exp_q = '0;
   logic        exp_sc = 1'b0;
   logic [31:0] last_bus;

   always #5 clk = ~clk;

   mcalu_top #(.W(32)) dut_i (
      .clk(clk), .rst(rst), .a_in(a_in), .m_in(m_in), .op_code(op_code),
      .op_cond(op_cond), .cin_sel(cin_sel), .q_ctl(q_ctl), .out_sel(out_sel),
      .mask_in(mask_in), .bus_out(bus_out), .carry_out(carry_out),
      .zero_out(zero_out), .ovf_out(ovf_out), .q_out(q_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Expected behaviour, taken from the requirements
   task automatic model(input logic c, input logic [4:0] op, input logic [1:0] cs,
                        input logic [1:0] qc, input logic [1:0] os,
                        input logic [31:0] a, input logic [31:0] m, input logic [31:0] mk,
                        input logic [31:0] q, input logic sc,
                        output logic [31:0] bus, output logic co, output logic ov,
                        output logic [31:0] qn);
      logic [31:0] x, y, r;
      logic [32:0] s;
      logic ci, ar;
      ci = (cs == 0) ? 1'b0 : (cs == 1) ? 1'b1 : (cs == 2) ? sc : q[0];
      x = a; y = '0; ar = 1'b0; r = '0;
      if (!c) begin
         case (op)
            0: r = ~a;         1: r = ~a & ~m;    2: r = ~a & m;     3: r = '0;
            4: r = ~(a & m);   5: r = ~m;         6: r = a ^ m;      7: r = a & ~m;
            8: r = ~a | m;     9: r = ~(a ^ m);   10: r = m;         11: r = a & m;
            12: r = '1;        13: r = a | ~m;    14: r = a | m;     15: r = a;
            16: begin ar = 1; y = 32'd1; end
            17: begin ar = 1; y = ~m; end
            18: begin ar = 1; y = m; end
            19: begin ar = 1; y = a; end
            20: begin ar = 1; y = '1; end
            default: r = '0;
         endcase
      end else begin
         if (op == 0) begin ar = 1; y = q[0] ? m : '0; end
         else if (op == 1) begin ar = 1; y = q[0] ? ~m : m; end
      end
      co = 1'b0; ov = 1'b0;
      if (ar) begin
         s  = {1'b0, x} + {1'b0, y} + {32'd0, ci};
         r  = s[31:0];
         co = s[32];
         ov = (x[31] == y[31]) && (r[31] != x[31]);
      end
      case (os)
         0: bus = r;
         1: bus = {co, r[31:1]};
         2: bus = {r[30:0], 1'b0};
         default: bus = mk;
      endcase
      case (qc)
         0: qn = q;
         1: qn = {q[30:0], ~r[31]};
         2: qn = {r[0], q[31:1]};
         default: qn = bus;
      endcase
   endtask

   // Apply one operation at a falling edge, check outputs, then the Q update
   task automatic step(input string tag, input logic c, input logic [4:0] op,
                       input logic [1:0] cs, input logic [1:0] qc, input logic [1:0] os,
                       input logic [31:0] a, input logic [31:0] m, input logic [31:0] mk);
      logic [31:0] eb, eq;
      logic ec, ev;
      op_cond = c; op_code = op; cin_sel = cs; q_ctl = qc; out_sel = os;
      a_in = a; m_in = m; mask_in = mk;
      #2;
      model(c, op, cs, qc, os, a, m, mk, exp_q, exp_sc, eb, ec, ev, eq);
      chk({tag, " bus"}, bus_out, eb);
      chk({tag, " carry"}, {31'd0, carry_out}, {31'd0, ec});
      chk({tag, " ovf"}, {31'd0, ovf_out}, {31'd0, ev});
      chk({tag, " zero(R7)"}, {31'd0, zero_out}, {31'd0, (eb == 0)});
      last_bus = bus_out;
      @(posedge clk);
      exp_q = eq; exp_sc = ec;
      @(negedge clk);
      chk({tag, " q"}, q_out, exp_q);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      exp_q = '0; exp_sc = 1'b0;
      chk("R1 q after reset", q_out, 32'd0);
   endtask

   task automatic t_reset();
      do_reset();
      // make both state elements non-zero, then reset again
      step("R1 setup", 0, 18, 0, 3, 0, 32'hFFFF_FFFF, 32'd2, 0);
      do_reset();
      step("R1 saved carry cleared", 0, 18, 2, 0, 0, 32'd0, 32'd0, 0);
   endtask

   task automatic t_boolean();
      for (int f = 0; f < 16; f++)
         step($sformatf("R2 code %0d", f), 0, 5'(f), 1, 0, 0, 32'h0F0F_33CC, 32'h00FF_5A5A, 0);
   endtask

   task automatic t_arith();
      step("R3 inca", 0, 16, 0, 0, 0, 32'd7, 32'd0, 0);
      step("R3 inca wrap", 0, 16, 0, 0, 0, 32'hFFFF_FFFF, 32'd0, 0);
      step("R3 sub neg", 0, 17, 1, 0, 0, 32'd5, 32'd7, 0);
      step("R3 sub pos", 0, 17, 1, 0, 0, 32'd7, 32'd5, 0);
      step("R7 add overflow", 0, 18, 0, 0, 0, 32'h7FFF_FFFF, 32'd1, 0);
      step("R3 lsha", 0, 19, 0, 0, 0, 32'h8000_0001, 32'd0, 0);
      step("R3 deca zero", 0, 20, 0, 0, 0, 32'd0, 32'd0, 0);
      step("R3 deca one", 0, 20, 0, 0, 0, 32'd1, 32'd0, 0);
   endtask

   task automatic t_unused();
      step("R4 code 21", 0, 21, 1, 0, 0, 32'h1234_5678, 32'h1111_1111, 0);
      step("R4 code 31", 0, 31, 1, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
      step("R4 cond 2", 1, 2, 1, 0, 0, 32'hFFFF_FFFF, 32'd1, 0);
      step("R4 cond 31", 1, 31, 1, 0, 0, 32'h8000_0000, 32'h8000_0000, 0);
   endtask

   task automatic t_carry();
      step("R5 cin zero", 0, 18, 0, 0, 0, 32'd10, 32'd20, 0);
      step("R5 cin one", 0, 18, 1, 0, 0, 32'd10, 32'd20, 0);
      step("R6 make carry", 0, 18, 0, 0, 0, 32'hFFFF_FFFF, 32'd1, 0);
      step("R6 use saved carry 1", 0, 18, 2, 0, 0, 32'd0, 32'd0, 0);
      step("R6 use saved carry 0", 0, 18, 2, 0, 0, 32'd0, 32'd0, 0);
      step("R5 load q odd", 0, 15, 0, 3, 0, 32'd1, 32'd0, 0);
      step("R5 cin q lsb", 0, 18, 3, 0, 0, 32'd0, 32'd0, 0);
   endtask

   task automatic t_outsel();
      step("R8 res", 0, 18, 0, 0, 0, 32'hFFFF_FFFF, 32'd3, 0);
      step("R8 shr carry fill", 0, 18, 0, 0, 1, 32'hFFFF_FFFF, 32'd3, 0);
      step("R8 shl", 0, 18, 0, 0, 2, 32'hC000_0001, 32'd0, 0);
      step("R8 masker", 0, 18, 0, 0, 3, 32'd1, 32'd1, 32'hA5A5_0F0F);
      step("R7 masker zero", 0, 12, 0, 0, 3, 32'd1, 32'd1, 32'd0);
   endtask

   task automatic t_qctl();
      step("R9 load", 0, 15, 0, 3, 0, 32'h8000_0001, 32'd0, 0);
      step("R9 hold", 0, 15, 0, 0, 0, 32'hDEAD_BEEF, 32'd0, 0);
      step("R9 shl fill", 0, 15, 0, 1, 0, 32'h8000_0000, 32'd0, 0);
      step("R9 shl fill 1", 0, 15, 0, 1, 0, 32'h0000_0000, 32'd0, 0);
      step("R9 shr fill", 0, 15, 0, 2, 0, 32'd1, 32'd0, 0);
      step("R9 shr fill 0", 0, 15, 0, 2, 0, 32'd2, 32'd0, 0);
   endtask

   task automatic t_mul();
      logic [31:0] acc;
      step("R10 load multiplier", 0, 15, 0, 3, 0, 32'd11, 32'd0, 0);
      acc = 32'd0;
      for (int i = 0; i < 4; i++) begin
         step($sformatf("R10 mul step %0d", i), 1, 0, 0, 2, 1, acc, 32'd13, 0);
         acc = last_bus;
      end
      chk("R10 product high", acc, 32'd8);
      chk("R10 product low", {28'd0, q_out[31:28]}, 32'hF);
   endtask

   task automatic t_div();
      step("R11 load q odd", 0, 15, 0, 3, 0, 32'd1, 32'd0, 0);
      step("R11 div subtract", 1, 1, 3, 0, 0, 32'd10, 32'd3, 0);
      step("R11 load q even", 0, 15, 0, 3, 0, 32'd2, 32'd0, 0);
      step("R11 div add", 1, 1, 3, 0, 0, 32'd10, 32'd3, 0);
      step("R11 div with q shift", 1, 1, 0, 1, 2, 32'd10, 32'd3, 0);
   endtask

   initial begin : watchdog
      #2_000_000;
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      t_reset();
      t_boolean();
      t_arith();
      t_unused();
      t_carry();
      t_outsel();
      t_qctl();
      t_mul();
      t_div();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule